// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block is a small cache of recent address translations. Each entry pairs a logical page number with a physical frame number. A lookup compares the requested page number against every entry at the same moment. On a hit the block returns the stored frame in the same cycle, so no page-table read in memory is needed. On a miss the block reports the miss in one of two ways, chosen by a mode input. In hardware-refill mode it raises a walk request for an external table walker. In software-refill mode it raises a miss trap, so that a handler fetches the translation and the access is retried.

In both modes the translation is installed through a single fill port that carries a page number and a frame number. The fill goes into the lowest-numbered empty entry when one exists. Otherwise it goes into the entry selected by a rotating pointer. A flush input empties the whole cache in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is empty, so every lookup misses, and the rotating replacement pointer is at entry 0.
- R2: `hit` is combinational on the current lookup and stored contents. It is high only when `lookupValid` is high and a valid entry's page equals `lookupPage`. `hitFrame` then carries that entry's frame, and `hitFrame` is zero whenever `hit` is low.
- R3: An empty entry never produces a hit, whatever page or frame bits it still holds.
- R4: With `swRefill` = 0, a valid lookup that misses raises `walkReq` in the same cycle and keeps `missTrap` low. A hit, or the absence of a lookup, raises neither.
- R5: With `swRefill` = 1, a valid lookup that misses raises `missTrap` in the same cycle and keeps `walkReq` low.
- R6: A fill with `fillValid` = 1 takes effect at the next rising clock edge. From then on a lookup of its page hits. A lookup in the same cycle as the fill still sees the old contents.
- R7: A fill goes into the lowest-indexed empty entry if any entry is empty. Otherwise it goes into the entry at the rotating pointer. The pointer advances by one, modulo 8, after every accepted fill of either kind.
- R8: `flushAll` empties all entries at the next edge. A lookup in the flush cycle reports a miss, and the flush does not move the rotating pointer.
- R9: A fill presented in the same cycle as `flushAll` is discarded.
- R10: If several valid entries hold the requested page, the frame of the lowest-indexed one is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| swRefill | input | 1 | 1: a miss raises missTrap; 0: a miss raises walkReq |
| flushAll | input | 1 | Empty every entry at the next edge |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupPage | input | PAGE_W (19) | Logical page number to translate |
| hit | output | 1 | Lookup found a valid matching entry |
| hitFrame | output | FRAME_W (19) | Frame of the winning entry, zero on a miss |
| walkReq | output | 1 | Miss in hardware-refill mode |
| missTrap | output | 1 | Miss in software-refill mode |
| fillValid | input | 1 | Install the pair on the fill port |
| fillPage | input | PAGE_W (19) | Logical page of the pair to install |
| fillFrame | input | FRAME_W (19) | Physical frame of the pair to install |

## Verification
The assertions take the reset as synchronous and all inputs as sampled at the rising edge. They assume that a fill is not followed, in the next cycle, by a flush that hides the installed page before it is looked up. The stimulus changes every input only on the falling edge, holds it for a whole period and never combines a fill with a flush except in the one cycle that tests the discard. A model of the eight entries in the bench computes the lowest-index winner, the empty-first victim and the pointer position. After every fill or flush it sweeps every page used so far in both refill modes.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  // Strobes from the control to the entry store
  typedef struct packed {
    logic writeEn;   // install the fill pair into the selected victim
    logic clearAll;  // drop every valid bit
  } xlat_strobe_t;
endpackage

// File: rtl/xlat_store.sv
`timescale 1ns/1ps
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N       = 8,
  parameter int PAGE_W  = 19,
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlat_strobe_t       strobe,
  input  logic [N-1:0]       victimOh,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic [PAGE_W-1:0]  lookupPage,
  output logic [N-1:0]       validVec,
  output logic               anyMatch,
  output logic [FRAME_W-1:0] matchFrame
);

  logic [N-1:0]              matchVec;
  logic [N-1:0][FRAME_W-1:0] frameVec;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic               validQ;
    logic [PAGE_W-1:0]  tagQ;
    logic [FRAME_W-1:0] frameQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ <= 1'b0;
        tagQ   <= '0;
        frameQ <= '0;
      end else if (strobe.clearAll) begin
        validQ <= 1'b0;
      end else if (strobe.writeEn && victimOh[g]) begin
        validQ <= 1'b1;
        tagQ   <= fillPage;
        frameQ <= fillFrame;
      end
    end

    assign validVec[g] = validQ;
    assign matchVec[g] = validQ && (tagQ == lookupPage);
    assign frameVec[g] = frameQ;
  end

  // Lowest index wins when several entries match
  always_comb begin
    matchFrame = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (matchVec[i]) matchFrame = frameVec[i];
    end
  end

  assign anyMatch = |matchVec;

endmodule

// File: rtl/xlat_ctrl.sv
`timescale 1ns/1ps
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swRefill,
  input  logic         flushAll,
  input  logic         lookupValid,
  input  logic         fillValid,
  input  logic [N-1:0] validVec,
  input  logic         anyMatch,
  output xlat_strobe_t strobe,
  output logic [N-1:0] victimOh,
  output logic         hit,
  output logic         walkReq,
  output logic         missTrap
);

  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] pickIdx;
  logic             freeFound;
  logic             missNow;

  // Lowest-indexed empty entry, else the rotating pointer
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    pickIdx = freeFound ? freeIdx : rrPtr;
  end

  for (genvar g = 0; g < N; g++) begin : g_oh
    assign victimOh[g] = (pickIdx == IDX_W'(g));
  end

  assign strobe.clearAll = flushAll;
  assign strobe.writeEn  = fillValid && !flushAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobe.writeEn) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  assign hit      = lookupValid && anyMatch && !flushAll;
  assign missNow  = lookupValid && !hit;
  assign walkReq  = missNow && !swRefill;
  assign missTrap = missNow && swRefill;

endmodule

// File: rtl/xlat_buffer.sv
`timescale 1ns/1ps
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int N       = 8,
  parameter int PAGE_W  = 19,
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swRefill,
  input  logic               flushAll,
  input  logic               lookupValid,
  input  logic [PAGE_W-1:0]  lookupPage,
  output logic               hit,
  output logic [FRAME_W-1:0] hitFrame,
  output logic               walkReq,
  output logic               missTrap,
  input  logic               fillValid,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [FRAME_W-1:0] fillFrame
);

  xlat_strobe_t       strobe;
  logic [N-1:0]       victimOh;
  logic [N-1:0]       validVec;
  logic               anyMatch;
  logic [FRAME_W-1:0] matchFrame;

  xlat_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swRefill   (swRefill),
    .flushAll   (flushAll),
    .lookupValid(lookupValid),
    .fillValid  (fillValid),
    .validVec   (validVec),
    .anyMatch   (anyMatch),
    .strobe     (strobe),
    .victimOh   (victimOh),
    .hit        (hit),
    .walkReq    (walkReq),
    .missTrap   (missTrap)
  );

  xlat_store #(.N(N), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .victimOh  (victimOh),
    .fillPage  (fillPage),
    .fillFrame (fillFrame),
    .lookupPage(lookupPage),
    .validVec  (validVec),
    .anyMatch  (anyMatch),
    .matchFrame(matchFrame)
  );

  assign hitFrame = hit ? matchFrame : '0;

endmodule

// File: rtl/xlat_buffer_chk.sv
`timescale 1ns/1ps
module xlat_buffer_chk #(
  parameter int PAGE_W  = 19,
  parameter int FRAME_W = 19
) (
  input logic               clk,
  input logic               rstN,
  input logic               swRefill,
  input logic               flushAll,
  input logic               lookupValid,
  input logic [PAGE_W-1:0]  lookupPage,
  input logic               hit,
  input logic [FRAME_W-1:0] hitFrame,
  input logic               walkReq,
  input logic               missTrap,
  input logic               fillValid,
  input logic [PAGE_W-1:0]  fillPage
);

  // R1: the first cycle out of reset sees an empty cache
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !hit);

  // R2: a miss drives a zero frame
  p_zero_frame_on_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitFrame == '0));

  // R2: a hit needs a lookup and never coexists with a miss indication
  p_hit_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (lookupValid && !walkReq && !missTrap));

  // R4: a walk request only for a hardware-mode miss
  p_walk_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |-> (!swRefill && lookupValid && !hit && !missTrap));

  // R5: a trap only for a software-mode miss
  p_trap_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    missTrap |-> (swRefill && lookupValid && !hit));

  // R4 and R5: every valid lookup ends in exactly one outcome
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $onehot({hit, walkReq, missTrap}));

  // R6: a fill is visible to a lookup of the same page one cycle later
  p_fill_visible_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(fillValid) && !$past(flushAll) && !flushAll &&
     lookupValid && (lookupPage == $past(fillPage))) |-> hit);

  // R8 and R9: after a flush (with or without a fill) nothing hits
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(flushAll)) |-> !hit);

  // R8: no hit during the flush cycle
  p_flush_cycle_miss_r8: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !hit);

endmodule

bind xlat_buffer xlat_buffer_chk #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .swRefill   (swRefill),
  .flushAll   (flushAll),
  .lookupValid(lookupValid),
  .lookupPage (lookupPage),
  .hit        (hit),
  .hitFrame   (hitFrame),
  .walkReq    (walkReq),
  .missTrap   (missTrap),
  .fillValid  (fillValid),
  .fillPage   (fillPage)
);

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;

  localparam int N  = 8;
  localparam int PW = 19;
  localparam int FW = 19;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          swRefill = 1'b0;
  logic          flushAll = 1'b0;
  logic          lookupValid = 1'b0;
  logic [PW-1:0] lookupPage = '0;
  logic          hit;
  logic [FW-1:0] hitFrame;
  logic          walkReq;
  logic          missTrap;
  logic          fillValid = 1'b0;
  logic [PW-1:0] fillPage = '0;
  logic [FW-1:0] fillFrame = '0;

  int checks = 0;
  int errors = 0;

  // Model of the cache contents
  logic          mValid [N];
  logic [PW-1:0] mPage  [N];
  logic [FW-1:0] mFrame [N];
  int            mPtr;

  logic [PW-1:0] used [64];
  int            nUsed = 0;

  always #4 clk = ~clk;   // 125 MHz

  xlat_buffer u0 (
    .clk(clk), .rstN(rstN), .swRefill(swRefill), .flushAll(flushAll),
    .lookupValid(lookupValid), .lookupPage(lookupPage), .hit(hit),
    .hitFrame(hitFrame), .walkReq(walkReq), .missTrap(missTrap),
    .fillValid(fillValid), .fillPage(fillPage), .fillFrame(fillFrame)
  );

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [FW-1:0] frameOf(input logic [PW-1:0] p);
    return p ^ 19'h2A5C3;
  endfunction

  task automatic addUsed(input logic [PW-1:0] p);
    for (int k = 0; k < nUsed; k++) if (used[k] == p) return;
    used[nUsed] = p;
    nUsed++;
  endtask

  // One clock: drive on the falling edge, check outputs, commit at the rising edge
  task automatic step(input logic lv, input logic [PW-1:0] pg,
                      input logic fv, input logic [PW-1:0] fp,
                      input logic [FW-1:0] ff, input logic fl,
                      input logic sw, input string tag);
    logic          eHit;
    logic [FW-1:0] eFrame;
    int            vic;
    lookupValid = lv; lookupPage = pg; fillValid = fv; fillPage = fp;
    fillFrame = ff; flushAll = fl; swRefill = sw;
    #1;
    eHit = 1'b0; eFrame = '0;
    if (lv && !fl) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (mValid[i] && mPage[i] == pg) begin
          eHit = 1'b1; eFrame = mFrame[i];
        end
      end
    end
    checks++;
    if (hit !== eHit || hitFrame !== eFrame ||
        walkReq !== (lv && !eHit && !sw) || missTrap !== (lv && !eHit && sw)) begin
      errors++;
      $display("FAIL %s page=%h actual hit=%b frame=%h walk=%b trap=%b expected hit=%b frame=%h walk=%b trap=%b",
               tag, pg, hit, hitFrame, walkReq, missTrap, eHit, eFrame,
               lv && !eHit && !sw, lv && !eHit && sw);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else if (fv) begin
      vic = -1;
      for (int i = N - 1; i >= 0; i--) if (!mValid[i]) vic = i;
      if (vic < 0) vic = mPtr;
      mValid[vic] = 1'b1; mPage[vic] = fp; mFrame[vic] = ff;
      mPtr = (mPtr + 1) % N;
    end
    @(negedge clk);
    lookupValid = 1'b0; fillValid = 1'b0; flushAll = 1'b0;
  endtask

  // Look up every page seen so far, alternating refill mode
  task automatic sweep(input string tag);
    for (int k = 0; k < nUsed; k++)
      step(1'b1, used[k], 1'b0, '0, '0, 1'b0, k[0], tag);
    step(1'b1, 19'h55555, 1'b0, '0, '0, 1'b0, 1'b1, tag);
    step(1'b0, used[0], 1'b0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic fill(input logic [PW-1:0] p, input logic [FW-1:0] f,
                      input logic [PW-1:0] lookP, input string tag);
    addUsed(p);
    step(1'b1, lookP, 1'b1, p, f, 1'b0, 1'b0, tag);
  endtask

  logic [PW-1:0] pg;

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 1'b0; mPage[i] = '0; mFrame[i] = '0;
    end
    mPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 and R3: empty after reset, including the all-zero page
    addUsed(19'h00000);
    addUsed(19'h7FFFF);
    step(1'b1, 19'h00000, 1'b0, '0, '0, 1'b0, 1'b0, "R1");
    step(1'b1, 19'h7FFFF, 1'b0, '0, '0, 1'b0, 1'b1, "R3");
    step(1'b0, 19'h00000, 1'b0, '0, '0, 1'b0, 1'b0, "R4");

    // R6: fill empty entries; a lookup in the fill cycle sees old contents
    for (int i = 0; i < 5; i++) begin
      pg = PW'(i * 32'h0A3F1 + 32'h11);
      fill(pg, frameOf(pg), pg, "R6");
      sweep("R6");
    end

    // R4 and R5: miss indications in both modes on a known-absent page
    step(1'b1, 19'h12345, 1'b0, '0, '0, 1'b0, 1'b0, "R4");
    step(1'b1, 19'h12345, 1'b0, '0, '0, 1'b0, 1'b1, "R5");

    // R7: fill up with boundary pages, then rotate through replacement
    fill(19'h00000, 19'h7FFFF, 19'h00000, "R6");
    fill(19'h7FFFF, 19'h00001, 19'h7FFFF, "R6");
    fill(19'h40000, 19'h3FFFF, 19'h00000, "R7");
    sweep("R2");
    for (int i = 5; i < 9; i++) begin
      pg = PW'(i * 32'h0A3F1 + 32'h11);
      fill(pg, frameOf(pg), 19'h7FFFF, "R7");
      sweep("R7");
    end

    // R10: duplicate of entry 0's page lands at a higher entry
    fill(mPage[0], mFrame[0] ^ 19'h00F0F, mPage[0], "R10");
    step(1'b1, mPage[0], 1'b0, '0, '0, 1'b0, 1'b0, "R10");
    sweep("R10");

    // R8 and R9: flush with a lookup and a fill in the same cycle
    addUsed(19'h6ABCD);
    step(1'b1, mPage[2], 1'b1, 19'h6ABCD, 19'h01234, 1'b1, 1'b0, "R8");
    sweep("R9");

    // R8: pointer survived the flush; refill from entry 0 then rotate
    for (int i = 9; i < 19; i++) begin
      pg = PW'(i * 32'h0A3F1 + 32'h11);
      fill(pg, frameOf(pg), pg, "R7");
      sweep("R8");
    end

    // R1: reset again clears contents and pointer
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    mPtr = 0;
    sweep("R1");
    for (int i = 0; i < 9; i++) begin
      pg = PW'(i * 32'h1D2B7 + 32'h5);
      fill(pg, frameOf(pg), pg, "R1");
    end
    sweep("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule